// File: doc/BRIEF.md
# PCI Configuration-Space Port Decoder

This block sits in a host bridge and watches a simple I/O bus: a 16-bit byte address, read and write strobes, four byte enables and 32-bit data. It owns two byte-wide control registers that share one dword of I/O space at 0xCF8. Lane 0 (0xCF8) is the enable register and lane 2 (0xCFA) is the forward register, which holds the bus number. Software loads the bus number first and then writes the enable register. After that, the block turns full-dword I/O accesses in page 0xC000–0xCFFF into configuration requests for a downstream cycle engine.

A request carries the bus, device, function, register index, direction and write data. The request is held until the engine acknowledges it, and then the I/O cycle completes. Once configuration is on, the control registers are locked: reads return all ones and writes are dropped, so only reset can turn configuration off again. A window access that is not a full, aligned dword never reaches the engine. The block rejects it and pulses an error instead.

Top module: `cfg_port_decoder`

## Requirements
- R1: After reset the enable and forward registers are zero. cfg_req, cfg_err, io_done and cfg_special are all low.
- R2: While configuration is off, a write with io_be[0] set at dword 0xCF8 loads io_wdata[7:0] into the enable register. Bit 0 drives cfg_special, bits 3:1 are the function number, and a non-zero value in bits 7:4 turns configuration on.
- R3: While configuration is off, a write with io_be[2] set at dword 0xCF8 (byte 0xCFA) loads io_wdata[23:16] as the bus number. A read of that dword returns {8'hFF, forward, 8'hFF, enable}. Once configuration is on, forward writes are ignored, and cfg_bus keeps the value loaded earlier.
- R4: Once configuration is on, reads of dword 0xCF8 return 32'hFFFFFFFF and writes there change nothing. Configuration stays on until reset.
- R5: While configuration is off, accesses in 0xC000–0xCFFF are not claimed. They complete with read data 32'hFFFFFFFF, with no request and no error.
- R6: While configuration is on, a window access (other than dword 0xCF8) with io_be = 4'hF and address bits 7:6 and 1:0 zero raises cfg_req one cycle after the strobe. The request carries cfg_dev = addr[11:8], cfg_reg = addr[5:2], cfg_func = enable[3:1], cfg_bus = forward, cfg_we = write, and cfg_wdata.
- R7: cfg_req and its fields stay stable until cfg_ack is sampled high. io_done follows one cycle after that edge. A read returns cfg_rdata and a write returns all ones.
- R8: A window access with io_be other than 4'hF raises a one-cycle cfg_err together with io_done, returns all ones, and raises no request.
- R9: A window access with address bits 7:6 or 1:0 non-zero is rejected in the same way as R8.
- R10: Every access that is not forwarded, including one outside both regions, completes with io_done one cycle after the strobe. Any read of it returns all ones, except the control dword while configuration is off (R3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| io_addr | input | 16 | I/O byte address |
| io_rd | input | 1 | Read strobe, one cycle |
| io_wr | input | 1 | Write strobe, one cycle |
| io_be | input | 4 | Byte enables |
| io_wdata | input | 32 | I/O write data |
| io_rdata | output | 32 | I/O read data, valid with io_done |
| io_done | output | 1 | I/O cycle complete pulse |
| cfg_req | output | 1 | Configuration request to the cycle engine |
| cfg_bus | output | 8 | Bus number |
| cfg_dev | output | 4 | Device number |
| cfg_func | output | 3 | Function number |
| cfg_reg | output | 4 | Dword register index |
| cfg_we | output | 1 | Request is a write |
| cfg_wdata | output | 32 | Request write data |
| cfg_special | output | 1 | Special-cycle enable bit |
| cfg_ack | input | 1 | Engine acknowledge |
| cfg_rdata | input | 32 | Engine read data |
| cfg_err | output | 1 | Rejected-access pulse |

## Verification
A local or rejected access completes one cycle after the strobe edge: io_done, io_rdata and cfg_err are all visible at the next falling edge. A valid window access shows cfg_req at that same falling edge. io_done then appears one cycle after the edge that samples cfg_ack, so a request acknowledged after k cycles completes k+1 falling edges after the strobe. Each scenario task drives the inputs on falling edges and counts falling edges from the strobe. It checks the latency as well as the data, records the request fields every cycle to show they stay stable, and confirms at the following edge that cfg_err has dropped.

// File: rtl/cfg_port_decoder.sv
module cfg_port_decoder #(
  parameter logic [15:0] CTRL_ADDR = 16'hCF8,
  parameter logic [3:0]  WIN_PAGE  = 4'hC
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] io_addr,
  input  logic        io_rd,
  input  logic        io_wr,
  input  logic [3:0]  io_be,
  input  logic [31:0] io_wdata,
  output logic [31:0] io_rdata,
  output logic        io_done,
  output logic        cfg_req,
  output logic [7:0]  cfg_bus,
  output logic [3:0]  cfg_dev,
  output logic [2:0]  cfg_func,
  output logic [3:0]  cfg_reg,
  output logic        cfg_we,
  output logic [31:0] cfg_wdata,
  output logic        cfg_special,
  input  logic        cfg_ack,
  input  logic [31:0] cfg_rdata,
  output logic        cfg_err
);
  localparam logic [13:0] CTRL_DW = CTRL_ADDR[15:2];
  localparam logic [31:0] ONES = '1;

  logic [7:0] en_q, fwd_q;
  logic       busy;

  wire cfg_on   = |en_q[7:4];
  wire strobe   = (io_rd | io_wr) & ~busy;
  wire hit_ctrl = io_addr[15:2] == CTRL_DW;
  wire hit_win  = cfg_on & (io_addr[15:12] == WIN_PAGE) & ~hit_ctrl;
  wire bad      = (io_be != 4'hF) | (io_addr[7:6] != 2'b00) | (io_addr[1:0] != 2'b00);

  assign cfg_req     = busy;
  assign cfg_bus     = fwd_q;
  assign cfg_func    = en_q[3:1];
  assign cfg_special = en_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= '0;
      fwd_q     <= '0;
      busy      <= 1'b0;
      io_done   <= 1'b0;
      io_rdata  <= '0;
      cfg_err   <= 1'b0;
      cfg_dev   <= '0;
      cfg_reg   <= '0;
      cfg_we    <= 1'b0;
      cfg_wdata <= '0;
    end else begin
      io_done <= 1'b0;
      cfg_err <= 1'b0;
      if (busy) begin
        if (cfg_ack) begin
          busy     <= 1'b0;
          io_done  <= 1'b1;
          io_rdata <= cfg_we ? ONES : cfg_rdata;
        end
      end else if (strobe) begin
        io_done  <= 1'b1;
        io_rdata <= ONES;
        if (hit_win) begin
          if (bad) begin
            cfg_err <= 1'b1;
          end else begin
            io_done   <= 1'b0;
            busy      <= 1'b1;
            cfg_dev   <= io_addr[11:8];
            cfg_reg   <= io_addr[5:2];
            cfg_we    <= io_wr;
            cfg_wdata <= io_wdata;
          end
        end else if (hit_ctrl && !cfg_on) begin
          if (io_wr) begin
            if (io_be[0]) en_q  <= io_wdata[7:0];
            if (io_be[2]) fwd_q <= io_wdata[23:16];
          end else begin
            io_rdata <= {8'hFF, fwd_q, 8'hFF, en_q};
          end
        end
      end
    end
  end
endmodule

// File: rtl/cfg_port_decoder_chk.sv
module cfg_port_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_on,
  input logic [7:0] fwd_q,
  input logic       cfg_req,
  input logic       cfg_ack,
  input logic [3:0] cfg_dev,
  input logic [3:0] cfg_reg,
  input logic [31:0] cfg_wdata,
  input logic       cfg_err,
  input logic       io_done
);
  // R4
  enable_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_on |=> cfg_on);
  // R3
  fwd_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_on |=> $stable(fwd_q));
  // R6
  req_needs_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req |-> cfg_on);
  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req && !cfg_ack) |=> (cfg_req && $stable(cfg_dev) && $stable(cfg_reg) && $stable(cfg_wdata)));
  // R8
  err_completes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> (io_done && !cfg_req));
  // R8
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> !cfg_err);
endmodule

bind cfg_port_decoder cfg_port_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_on(cfg_on), .fwd_q(fwd_q),
  .cfg_req(cfg_req), .cfg_ack(cfg_ack), .cfg_dev(cfg_dev), .cfg_reg(cfg_reg),
  .cfg_wdata(cfg_wdata), .cfg_err(cfg_err), .io_done(io_done)
);

// File: tb/cfg_port_decoder_test.sv
`timescale 1ns/1ps
module cfg_port_decoder_test;
  logic clk = 0, rst_n = 0;
  logic [15:0] io_addr = 0;
  logic io_rd = 0, io_wr = 0;
  logic [3:0] io_be = 0;
  logic [31:0] io_wdata = 0, io_rdata;
  logic io_done, cfg_req, cfg_we, cfg_special, cfg_err;
  logic [7:0] cfg_bus;
  logic [3:0] cfg_dev, cfg_reg;
  logic [2:0] cfg_func;
  logic [31:0] cfg_wdata;
  logic cfg_ack = 0;
  logic [31:0] cfg_rdata = 0;

  int compared = 0, mismatched = 0;
  logic [31:0] r_rdata;
  logic r_err, r_req, r_unstable, r_errlong;
  int r_lat;
  logic [7:0] r_bus; logic [3:0] r_dev, r_reg; logic [2:0] r_func; logic r_we; logic [31:0] r_wdata;

  always #2.5 clk = ~clk;

  cfg_port_decoder uut (.*);

  initial begin
    #200000;
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic io_op(input logic [15:0] a, input logic [3:0] be, input logic wr,
                       input logic [31:0] wd, input int ackdly, input logic [31:0] ad);
    int cnt;
    @(negedge clk);
    io_addr = a; io_be = be; io_wdata = wd; io_wr = wr; io_rd = !wr;
    @(negedge clk);
    io_wr = 0; io_rd = 0;
    r_req = 0; r_err = 0; r_unstable = 0; r_errlong = 0; r_lat = -1; r_rdata = 'x; cnt = 0;
    for (int i = 0; i < 50; i++) begin
      if (io_done) begin
        r_lat = i; r_rdata = io_rdata; r_err = cfg_err;
        break;
      end
      if (cfg_req) begin
        if (!r_req) begin
          r_req = 1; r_bus = cfg_bus; r_dev = cfg_dev; r_reg = cfg_reg;
          r_func = cfg_func; r_we = cfg_we; r_wdata = cfg_wdata;
        end else if (cfg_dev !== r_dev || cfg_reg !== r_reg || cfg_wdata !== r_wdata || cfg_we !== r_we)
          r_unstable = 1;
        if (cnt == ackdly) begin cfg_ack = 1; cfg_rdata = ad; end
        cnt++;
      end
      @(negedge clk);
      cfg_ack = 0;
    end
    @(negedge clk);
    r_errlong = cfg_err;
  endtask

  task automatic t_reset;
    chk("R1 io_done", io_done, 0);
    chk("R1 cfg_req", cfg_req, 0);
    chk("R1 cfg_err", cfg_err, 0);
    chk("R1 cfg_special", cfg_special, 0);
    io_op(16'h0CF8, 4'hF, 0, 0, 0, 0);
    chk("R1 control regs zero", r_rdata, 32'hFF00FF00);
    chk("R10 local latency", r_lat, 0);
  endtask

  task automatic t_setup;
    io_op(16'h0CFA, 4'b0100, 1, 32'h005A0000, 0, 0);
    io_op(16'h0CF8, 4'hF, 0, 0, 0, 0);
    chk("R3 forward readback", r_rdata, 32'hFF5AFF00);
    io_op(16'hC104, 4'hF, 0, 0, 0, 0);
    chk("R5 window off data", r_rdata, 32'hFFFFFFFF);
    chk("R5 window off no req", r_req, 0);
    chk("R5 window off no err", r_err, 0);
    io_op(16'h0CF8, 4'b0001, 1, 32'h000000A5, 0, 0);
    chk("R2 special bit", cfg_special, 1);
    chk("R2 function field", cfg_func, 3'd2);
  endtask

  task automatic t_lockout;
    io_op(16'h0CF8, 4'hF, 0, 0, 0, 0);
    chk("R4 control read ones", r_rdata, 32'hFFFFFFFF);
    io_op(16'h0CFA, 4'b0100, 1, 32'h00330000, 0, 0);
    chk("R3 forward write ignored", cfg_bus, 8'h5A);
    io_op(16'h0CF8, 4'b0001, 1, 32'h00000000, 0, 0);
    chk("R4 enable not cleared func", cfg_func, 3'd2);
    chk("R4 enable not cleared special", cfg_special, 1);
  endtask

  task automatic t_decode;
    io_op(16'hC314, 4'hF, 0, 0, 2, 32'h12345678);
    chk("R6 req seen", r_req, 1);
    chk("R6 bus", r_bus, 8'h5A);
    chk("R6 dev", r_dev, 4'h3);
    chk("R6 reg", r_reg, 4'h5);
    chk("R6 func", r_func, 3'd2);
    chk("R6 dir read", r_we, 0);
    chk("R7 read data", r_rdata, 32'h12345678);
    chk("R7 latency", r_lat, 3);
    chk("R7 stable", r_unstable, 0);
    io_op(16'hCF3C, 4'hF, 1, 32'hDEADBEEF, 0, 0);
    chk("R6 dev max", r_dev, 4'hF);
    chk("R6 reg max", r_reg, 4'hF);
    chk("R6 dir write", r_we, 1);
    chk("R6 wdata", r_wdata, 32'hDEADBEEF);
    chk("R7 write returns ones", r_rdata, 32'hFFFFFFFF);
    chk("R7 latency ack0", r_lat, 1);
    io_op(16'hC000, 4'hF, 0, 0, 5, 32'h00000001);
    chk("R6 dev0 reg0", {r_dev, r_reg}, 8'h00);
    chk("R7 latency ack5", r_lat, 6);
  endtask

  task automatic t_reject;
    io_op(16'hC000, 4'b0001, 0, 0, 0, 0);
    chk("R8 byte err", r_err, 1);
    chk("R8 byte no req", r_req, 0);
    chk("R8 byte data", r_rdata, 32'hFFFFFFFF);
    chk("R8 err one cycle", r_errlong, 0);
    io_op(16'hC200, 4'b0011, 1, 32'h11111111, 0, 0);
    chk("R8 word err", r_err, 1);
    chk("R8 word no req", r_req, 0);
    io_op(16'hC040, 4'hF, 0, 0, 0, 0);
    chk("R9 bit6 err", r_err, 1);
    chk("R9 bit6 no req", r_req, 0);
    io_op(16'hC001, 4'hF, 0, 0, 0, 0);
    chk("R9 bit0 err", r_err, 1);
    chk("R9 latency", r_lat, 0);
  endtask

  task automatic t_outside;
    io_op(16'h0080, 4'hF, 0, 0, 0, 0);
    chk("R10 outside data", r_rdata, 32'hFFFFFFFF);
    chk("R10 outside no err", r_err, 0);
    chk("R10 outside no req", r_req, 0);
    chk("R10 outside latency", r_lat, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_setup;
    t_lockout;
    t_decode;
    t_reject;
    t_outside;
    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule